// File: doc/BRIEF.md
# Cascaded GPIO Interrupt Controller

The block turns twelve general-purpose input pins into interrupt sources. Each pin first passes through a synchronizer and then a qualification counter. The pin only counts once its active level has been seen for a set number of consecutive clock cycles. A qualified pin sets a sticky status bit, whether or not that pin is enabled. Software clears a status bit by writing a one to it.

The status bits are ANDed with per-pin enables and ORed into one summary bit. The summary bit appears as bit 12 of a top-level status word. A top-level enable bit, also at position 12, gates the summary onto the `irq_o` output. Each pin's active level is set by a polarity input, not by software.

Software reaches the block through a flat 32-bit register port. The port has a write strobe, a two-bit word address and a combinational read path. Address 0 holds the per-pin status and enable word, address 1 holds the top-level status, and address 2 holds the top-level enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, all status bits, per-pin enables and the top-level enable are 0. `irq_o` is 0 and every address reads 0.
- R2: At address 0, bits 11:0 read the per-pin status and bits 27:16 read the per-pin enables. Bits 31:28 and 15:12 always read 0, and writes to them are ignored.
- R3: Writing address 0 loads bits 27:16 into the per-pin enables. The enables change on no other write.
- R4: A qualified active level on a pin sets that pin's status bit even when the pin's enable is 0. The bit stays set after the pin goes inactive.
- R5: A pin qualifies only if its synchronized active level lasts at least QUAL_CYCLES consecutive clock cycles (default 5, which is 50 ns at 100 MHz). A shorter pulse sets nothing. With the default two synchronizer stages, status rises QUAL_CYCLES+3 clock edges after the pin changes.
- R6: `gpio_pol_i[i]` = 1 makes pin i active high. `gpio_pol_i[i]` = 0 makes it active low.
- R7: Writing 1 to a status bit at address 0 clears it. Writing 0 leaves it unchanged.
- R8: If a pin is qualified in the same cycle as a clearing write to its bit, the set wins. The bit keeps setting for as long as the level stays active.
- R9: Address 1 reads, in bit 12, the OR over all pins of (status AND enable). Every other bit reads 0, and the word ignores writes.
- R10: Address 2 bit 12 is a read/write top-level enable. Its other bits read 0. `irq_o` is high exactly when that bit and the summary bit are both 1.
- R11: Address 3 reads 0, and writes to it change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 pin word, 1 top status, 2 top enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| gpio_i | input | 12 | Asynchronous pin inputs |
| gpio_pol_i | input | 12 | Per-pin active level, 1 means high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
A pin change reaches its status bit QUAL_CYCLES+3 edges later. That count is two synchronizer stages, QUAL_CYCLES counter increments and one status register. The summary bit, the top-level status read and `irq_o` follow the status bit in the same cycle, with no added delay. The vector loop holds every pin setting for twelve cycles before it writes or reads, so all pin effects have settled before sampling. Register writes take effect at the next edge, so each read happens at the falling edge after the write. One directed test samples exactly at QUAL_CYCLES+2 and QUAL_CYCLES+3 edges to pin down the latency. Two others hold a pulse for QUAL_CYCLES-1 and for QUAL_CYCLES cycles to probe the qualification threshold.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned PIN_MAX = 12;
  localparam int unsigned STS_LSB = 0;
  localparam int unsigned EN_LSB  = 16;
  localparam int unsigned SUM_BIT = 12;

  typedef enum logic [1:0] {
    ADDR_PIN     = 2'd0,
    ADDR_TOP_STS = 2'd1,
    ADDR_TOP_EN  = 2'd2,
    ADDR_NONE    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio_pin_qual.sv
module gpio_pin_qual #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic qual_o
);
  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign active = (sync_q[SYNC_STAGES-1] == pol_i);

  // saturating run-length of the active level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!active)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic [NUM_PINS-1:0] qual_i,
  output logic [NUM_PINS-1:0] sts_o,
  output logic [NUM_PINS-1:0] en_o,
  output logic                top_en_o,
  output logic                summary_o,
  output logic [REG_W-1:0]    rdata_o
);
  reg_addr_e           addr_sel;
  logic                wr_pin, wr_top_en;
  logic [NUM_PINS-1:0] sts_q, en_q;
  logic                top_en_q;
  logic                unused_wdata;

  assign addr_sel     = reg_addr_e'(addr_i);
  assign wr_pin       = we_i && (addr_sel == ADDR_PIN);
  assign wr_top_en    = we_i && (addr_sel == ADDR_TOP_EN);
  assign unused_wdata = ^wdata_i;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_sts
    // set has priority over write-one-to-clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             sts_q[i] <= 1'b0;
      else if (qual_i[i])                      sts_q[i] <= 1'b1;
      else if (wr_pin && wdata_i[STS_LSB + i]) sts_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (wr_pin) en_q <= wdata_i[EN_LSB +: NUM_PINS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        top_en_q <= 1'b0;
    else if (wr_top_en) top_en_q <= wdata_i[SUM_BIT];
  end

  assign summary_o = |(sts_q & en_q);

  always_comb begin
    rdata_o = '0;
    unique case (addr_sel)
      ADDR_PIN: begin
        rdata_o[STS_LSB +: NUM_PINS] = sts_q;
        rdata_o[EN_LSB +: NUM_PINS]  = en_q;
      end
      ADDR_TOP_STS: rdata_o[SUM_BIT] = summary_o;
      ADDR_TOP_EN:  rdata_o[SUM_BIT] = top_en_q;
      default:      rdata_o = '0;
    endcase
  end

  assign sts_o    = sts_q;
  assign en_o     = en_q;
  assign top_en_o = top_en_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned QUAL_CYCLES = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  input  logic [NUM_PINS-1:0] gpio_i,
  input  logic [NUM_PINS-1:0] gpio_pol_i,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] pin_qual;
  logic [NUM_PINS-1:0] sts_vec, en_vec;
  logic                top_en_q, summary;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_pin_qual #(
      .SYNC_STAGES(SYNC_STAGES),
      .QUAL_CYCLES(QUAL_CYCLES)
    ) u_qual (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (gpio_i[i]),
      .pol_i (gpio_pol_i[i]),
      .qual_o(pin_qual[i])
    );
  end

  gpio_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .qual_i   (pin_qual),
    .sts_o    (sts_vec),
    .en_o     (en_vec),
    .top_en_o (top_en_q),
    .summary_o(summary),
    .rdata_o  (reg_rdata_o)
  );

  assign irq_o = summary & top_en_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_PINS = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                reg_we_i,
  input logic [1:0]          reg_addr_i,
  input logic [31:0]         reg_wdata_i,
  input logic [31:0]         reg_rdata_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] pin_qual,
  input logic [NUM_PINS-1:0] sts_vec,
  input logic [NUM_PINS-1:0] en_vec,
  input logic                top_en_q
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  // R7
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=>
      ((sts_vec & $past(reg_wdata_i[NUM_PINS-1:0] & ~pin_qual)) == '0));

  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_qual != '0) |=> ((sts_vec & $past(pin_qual)) == $past(pin_qual)));

  // R4
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_qual == '0) |=> ((sts_vec & ~$past(sts_vec)) == '0));

  // R3
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == 2'd0) |=> $stable(en_vec));

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (top_en_q && ((sts_vec & en_vec) != '0)));

  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd0) |-> (reg_rdata_o[31:28] == 4'h0 && reg_rdata_o[15:12] == 4'h0));

  // R11
  addr3_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd3) |-> (reg_rdata_o == 32'h0));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .pin_qual   (pin_qual),
  .sts_vec    (sts_vec),
  .en_vec     (en_vec),
  .top_en_q   (top_en_q)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int QUAL = 5;
  localparam int NV   = 15;

  typedef struct packed {
    logic [11:0] pins;
    logic [11:0] pol;
    logic        we;
    logic [1:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        exp_irq;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{12'h000, 12'hFFF, 1'b0, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd1 },  // R1
    '{12'h000, 12'hFFF, 1'b1, 2'd0, 32'h0005_0000, 32'h0005_0000, 1'b0, 8'd3 },  // R3
    '{12'h001, 12'hFFF, 1'b0, 2'd0, 32'h0,         32'h0005_0001, 1'b0, 8'd4 },  // R4
    '{12'h001, 12'hFFF, 1'b0, 2'd1, 32'h0,         32'h0000_1000, 1'b0, 8'd9 },  // R9
    '{12'h001, 12'hFFF, 1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0000_1000, 1'b1, 8'd10},  // R10
    '{12'h002, 12'hFFF, 1'b0, 2'd0, 32'h0,         32'h0005_0003, 1'b1, 8'd4 },  // R4 unenabled pin
    '{12'h002, 12'hFFF, 1'b1, 2'd0, 32'h0005_0001, 32'h0005_0002, 1'b0, 8'd7 },  // R7
    '{12'h002, 12'hFFF, 1'b0, 2'd1, 32'h0,         32'h0000_0000, 1'b0, 8'd9 },  // R9
    '{12'h000, 12'hFFF, 1'b1, 2'd0, 32'h0005_0002, 32'h0005_0000, 1'b0, 8'd7 },  // R7
    '{12'h000, 12'hFFF, 1'b1, 2'd0, 32'hF005_F000, 32'h0005_0000, 1'b0, 8'd2 },  // R2
    '{12'h000, 12'hFFB, 1'b0, 2'd0, 32'h0,         32'h0005_0004, 1'b1, 8'd6 },  // R6
    '{12'h004, 12'hFFB, 1'b1, 2'd0, 32'h0005_0004, 32'h0005_0000, 1'b0, 8'd6 },  // R6
    '{12'h004, 12'hFFB, 1'b1, 2'd3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 8'd11},  // R11
    '{12'h004, 12'hFFB, 1'b0, 2'd2, 32'h0,         32'h0000_1000, 1'b0, 8'd11},  // R11
    '{12'h004, 12'hFFB, 1'b1, 2'd2, 32'h0000_0000, 32'h0000_0000, 1'b0, 8'd10}   // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [11:0] gpio = '0;
  logic [11:0] pol = 12'hFFF;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl #(.QUAL_CYCLES(QUAL)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .gpio_i     (gpio),
    .gpio_pol_i (pol),
    .irq_o      (irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 during reset
    rd(2'd0, r); check("R1", r, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      gpio = VECS[v].pins;
      pol  = VECS[v].pol;
      repeat (12) @(negedge clk);
      if (VECS[v].we) wr(VECS[v].addr, VECS[v].wdata);
      rd(VECS[v].addr, r);
      check($sformatf("R%0d vec%0d", VECS[v].req, v), r, VECS[v].exp);
      check($sformatf("R%0d vec%0d irq", VECS[v].req, v), {31'h0, irq}, {31'h0, VECS[v].exp_irq});
    end

    gpio = '0; pol = 12'hFFF;
    repeat (12) @(negedge clk);
    wr(2'd0, 32'h0000_0FFF);

    // R5 pulse one cycle short of the threshold
    @(negedge clk); gpio[3] = 1'b1;
    repeat (QUAL - 1) @(posedge clk);
    @(negedge clk); gpio[3] = 1'b0;
    repeat (12) @(negedge clk);
    rd(2'd0, r); check("R5 short pulse", r, 32'h0);

    // R5 pulse exactly at the threshold
    @(negedge clk); gpio[3] = 1'b1;
    repeat (QUAL) @(posedge clk);
    @(negedge clk); gpio[3] = 1'b0;
    repeat (12) @(negedge clk);
    rd(2'd0, r); check("R5 exact pulse", r, 32'h0000_0008);
    wr(2'd0, 32'h0000_0008);

    // R5 latency
    @(negedge clk); gpio[4] = 1'b1;
    repeat (QUAL + 2) @(posedge clk);
    @(negedge clk);
    rd(2'd0, r); check("R5 latency early", r, 32'h0);
    @(negedge clk);
    rd(2'd0, r); check("R5 latency due", r, 32'h0000_0010);

    // R8 set beats clear while level stays active
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, r); check("R8 set wins", r, 32'h0000_0010);
    gpio[4] = 1'b0;
    repeat (12) @(negedge clk);
    wr(2'd0, 32'h0000_0010);
    rd(2'd0, r); check("R7 clear after release", r, 32'h0);

    // R1 reset mid-run
    wr(2'd0, 32'h0001_0000);
    wr(2'd2, 32'h0000_1000);
    gpio[0] = 1'b1;
    repeat (12) @(negedge clk);
    check("R10 irq before reset", {31'h0, irq}, 32'h1);
    rst_n = 1'b0;
    #1;
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    rd(2'd0, r); check("R1 pin word in reset", r, 32'h0);
    rd(2'd2, r); check("R1 top enable in reset", r, 32'h0);
    gpio = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    rd(2'd0, r); check("R1 after reset", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule